// File: doc/BRIEF.md
# Transfer Command and Status Queue Controller

This block sits between a host and two packet engines, one for sending and one for receiving. The host posts commands for either direction. The block holds them in a small queue for each direction and hands them one at a time to the matching engine through a valid/take handshake. When an engine finishes a packet, it pulses a completion strobe with a status word. The block stores that word in a per-direction status queue, where the host reads it and pops it. Because of these queues, back-to-back transfers can proceed while the host's interrupt service is delayed.

After reset the block runs in a legacy single-command mode. In this mode each queue holds one entry, so older host software sees a device that accepts one job at a time. Writing a configuration word with bit 6 set turns on chaining, which raises every queue to two entries. Writing the configuration with bit 6 clear while chaining is on drops every queued command and status entry and returns to legacy mode.

The interrupt output is driven only by stored completion entries. Each direction has one mask bit, and that bit acts on the completion flag, not on the command queue state.

Top module: `cmd_chain_ctrl`

## Requirements
- R1: After reset, both command queues and both status queues are empty, `irq` is 0, `cmd_ovf` is 0, and the block is in legacy mode.
- R2: In legacy mode each queue holds at most one entry. A second command for a direction whose single slot is occupied is ignored, and the head command stays unchanged.
- R3: A configuration write with bit 6 = 1 enables chaining. Each direction then holds two commands, and they are presented to the engine oldest first.
- R4: A command for a direction whose queue is at capacity is ignored. It sets that direction's sticky overflow bit (`cmd_ovf` bit 0 = transmit, bit 1 = receive). The bit stays set until reset or until chaining is turned off.
- R5: Transmit and receive commands are independent. Interleaving them in any order does not change either direction's queue contents.
- R6: A completion strobe stores its status word at the tail of that direction's status queue, and the head port shows the oldest stored word. A pop exposes the next entry. A completion that arrives when the status queue is at capacity (2 when chaining, 1 in legacy) is dropped.
- R7: `irq` rises only in the cycle after a completion strobe or a mask change. It stays 1 while any unmasked status entry remains queued and falls once those entries are popped.
- R8: `irq_mask` bit 0 blocks the transmit contribution to `irq` and bit 1 blocks the receive contribution. Masked entries stay queued and readable.
- R9: A configuration write with bit 6 = 0 while chaining is on empties all four queues, clears `cmd_ovf`, and returns the block to legacy mode.
- R10: A take strobe from an engine removes the head command, and the next queued command (if any) appears on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word; bit 6 selects chaining |
| irq_mask | input | 2 | Interrupt mask, bit 0 transmit, bit 1 receive |
| cmd_we | input | 1 | Host command write strobe |
| cmd_dir | input | 1 | Command direction, 0 transmit, 1 receive |
| cmd_data | input | CMD_W | Command word |
| tx_cmd_valid | output | 1 | A transmit command is waiting |
| tx_cmd_data | output | CMD_W | Oldest transmit command |
| tx_cmd_take | input | 1 | Transmit engine takes the head command |
| rx_cmd_valid | output | 1 | A receive command is waiting |
| rx_cmd_data | output | CMD_W | Oldest receive command |
| rx_cmd_take | input | 1 | Receive engine takes the head command |
| tx_done | input | 1 | Transmit packet completed |
| tx_status | input | STAT_W | Status of the completed transmission |
| rx_done | input | 1 | Receive packet completed |
| rx_status | input | STAT_W | Status of the completed reception |
| tx_stat_valid | output | 1 | Transmit status entry queued |
| tx_stat_head | output | STAT_W | Oldest transmit status |
| tx_stat_pop | input | 1 | Host pops the transmit status head |
| rx_stat_valid | output | 1 | Receive status entry queued |
| rx_stat_head | output | STAT_W | Oldest receive status |
| rx_stat_pop | input | 1 | Host pops the receive status head |
| cmd_ovf | output | 2 | Sticky command overflow, bit 0 transmit, bit 1 receive |
| irq | output | 1 | Interrupt request |

## Verification
The queues are tested with a repeated same-direction write in legacy mode and then in chaining mode. The difference between the two runs isolates the one-slot and two-slot capacities and the overflow flag. An interleaved receive/transmit/receive/transmit write sequence confirms that the two directions never share slots or ordering. Completion strobes are driven in bursts of three against a two-deep status queue, which checks ordering and the dropping of the extra entry. The interrupt is then run through each mask combination to show that masking changes `irq` while the status entries stay readable. A final run switches chaining off while every queue holds data, which separates a real flush from the legacy capacity limit.

// File: rtl/chain_pkg.sv
// Package: shared direction encoding and configuration field position.
// Assumes exactly two directions, transmit and receive.
package chain_pkg;
    typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;
    localparam int unsigned NDIR      = 2;
    localparam int unsigned CHAIN_BIT = 6;
endpackage

// File: rtl/chain_fifo.sv
// Module: chain_fifo
// Small queue with a runtime capacity limit (cap <= DEPTH) and a flush.
// Pushes beyond cap are dropped; a pop of an empty queue does nothing.
// Assumes cap never exceeds DEPTH.
module chain_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 2,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [CNT_W-1:0] cap,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic             valid,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Accept qualifiers: space for a push, an entry for a pop.
    always_comb begin
        full    = (count >= cap);
        do_push = push && !full;
        do_pop  = pop && (count != '0);
        valid   = (count != '0);
        head    = mem[rd_ptr];
    end

    // Pointer and occupancy update, flush overriding all traffic.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= push_data;
    end

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count)));
    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    // R10
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && valid && !push && !flush) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/chain_mode.sv
// Module: chain_mode
// Holds the chaining-enable bit, derives the queue capacity and issues a
// flush pulse when chaining is switched off. Reset leaves legacy mode.
module chain_mode #(
    parameter int unsigned DEPTH = 2,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic             chain_en,
    output logic             flush,
    output logic [CNT_W-1:0] cap
);
    import chain_pkg::*;

    // Flush on the write that turns chaining off; capacity from the mode.
    always_comb begin
        flush = cfg_we && !cfg_wdata[CHAIN_BIT] && chain_en;
        cap   = chain_en ? CNT_W'(DEPTH) : CNT_W'(1);
    end

    // Mode register, legacy after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      chain_en <= 1'b0;
        else if (cfg_we) chain_en <= cfg_wdata[CHAIN_BIT];
    end
endmodule

// File: rtl/chain_irq.sv
// Module: chain_irq
// Combines per-direction completion-pending flags under their masks.
module chain_irq #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] mask,
    output logic         irq
);
    // Any unmasked pending completion raises the request.
    always_comb irq = |(pend & ~mask);
endmodule

// File: rtl/cmd_chain_ctrl.sv
// Module: cmd_chain_ctrl
// Top: per-direction command queues feeding the packet engines, per-direction
// completion status queues read by the host, sticky overflow, masked irq.
// Assumes engines pulse take/done for one cycle per event.
module cmd_chain_ctrl #(
    parameter int unsigned CMD_W  = 8,
    parameter int unsigned STAT_W = 4,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic [1:0]        irq_mask,
    input  logic              cmd_we,
    input  logic              cmd_dir,
    input  logic [CMD_W-1:0]  cmd_data,
    output logic              tx_cmd_valid,
    output logic [CMD_W-1:0]  tx_cmd_data,
    input  logic              tx_cmd_take,
    output logic              rx_cmd_valid,
    output logic [CMD_W-1:0]  rx_cmd_data,
    input  logic              rx_cmd_take,
    input  logic              tx_done,
    input  logic [STAT_W-1:0] tx_status,
    input  logic              rx_done,
    input  logic [STAT_W-1:0] rx_status,
    output logic              tx_stat_valid,
    output logic [STAT_W-1:0] tx_stat_head,
    input  logic              tx_stat_pop,
    output logic              rx_stat_valid,
    output logic [STAT_W-1:0] rx_stat_head,
    input  logic              rx_stat_pop,
    output logic [1:0]        cmd_ovf,
    output logic              irq
);
    import chain_pkg::*;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic             chain_en, flush;
    logic [CNT_W-1:0] cap;
    logic [NDIR-1:0]  c_push, c_take, c_valid, c_full;
    logic [NDIR-1:0]  s_push, s_pop, s_valid, s_full;
    logic [CMD_W-1:0] c_head [NDIR];
    logic [STAT_W-1:0] s_in [NDIR];
    logic [STAT_W-1:0] s_head [NDIR];
    logic [CNT_W-1:0] c_cnt [NDIR];
    logic [CNT_W-1:0] s_cnt [NDIR];

    chain_mode #(.DEPTH(DEPTH)) u_mode (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .chain_en(chain_en), .flush(flush), .cap(cap)
    );

    // Steer host and engine strobes into per-direction vectors.
    always_comb begin
        c_push[DIR_TX] = cmd_we && (cmd_dir == DIR_TX);
        c_push[DIR_RX] = cmd_we && (cmd_dir == DIR_RX);
        c_take = {rx_cmd_take, tx_cmd_take};
        s_push = {rx_done, tx_done};
        s_pop  = {rx_stat_pop, tx_stat_pop};
        s_in[DIR_TX] = tx_status;
        s_in[DIR_RX] = rx_status;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        chain_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmdq (
            .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
            .push(c_push[d]), .push_data(cmd_data), .pop(c_take[d]),
            .valid(c_valid[d]), .head(c_head[d]), .count(c_cnt[d]), .full(c_full[d])
        );
        chain_fifo #(.W(STAT_W), .DEPTH(DEPTH)) u_statq (
            .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
            .push(s_push[d]), .push_data(s_in[d]), .pop(s_pop[d]),
            .valid(s_valid[d]), .head(s_head[d]), .count(s_cnt[d]), .full(s_full[d])
        );
    end

    // Sticky overflow per direction, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) cmd_ovf <= '0;
        else                 cmd_ovf <= cmd_ovf | (c_push & c_full);
    end

    chain_irq #(.N(NDIR)) u_irq (.pend(s_valid), .mask(irq_mask), .irq(irq));

    // Output mapping.
    always_comb begin
        tx_cmd_valid  = c_valid[DIR_TX];
        tx_cmd_data   = c_head[DIR_TX];
        rx_cmd_valid  = c_valid[DIR_RX];
        rx_cmd_data   = c_head[DIR_RX];
        tx_stat_valid = s_valid[DIR_TX];
        tx_stat_head  = s_head[DIR_TX];
        rx_stat_valid = s_valid[DIR_RX];
        rx_stat_head  = s_head[DIR_RX];
    end

    // R4
    ovf_sticky_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ovf[0] && !flush) |=> cmd_ovf[0]);
    // R4
    ovf_sticky_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ovf[1] && !flush) |=> cmd_ovf[1]);
    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !tx_done && !rx_done) |=> (!irq || (irq_mask != $past(irq_mask))));
    // R2
    legacy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en |-> (c_cnt[0] <= 1 && c_cnt[1] <= 1 && s_cnt[0] <= 1 && s_cnt[1] <= 1));
endmodule

// File: tb/sim_cmd_chain_ctrl.sv
`timescale 1ns/100ps
module sim_cmd_chain_ctrl;
    localparam int CMD_W = 8, STAT_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0; logic [7:0] cfg_wdata = 0; logic [1:0] irq_mask = 0;
    logic cmd_we = 0, cmd_dir = 0; logic [CMD_W-1:0] cmd_data = 0;
    logic tx_cmd_valid, rx_cmd_valid; logic [CMD_W-1:0] tx_cmd_data, rx_cmd_data;
    logic tx_cmd_take = 0, rx_cmd_take = 0;
    logic tx_done = 0, rx_done = 0; logic [STAT_W-1:0] tx_status = 0, rx_status = 0;
    logic tx_stat_valid, rx_stat_valid; logic [STAT_W-1:0] tx_stat_head, rx_stat_head;
    logic tx_stat_pop = 0, rx_stat_pop = 0;
    logic [1:0] cmd_ovf; logic irq;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cmd_chain_ctrl #(.CMD_W(CMD_W), .STAT_W(STAT_W), .DEPTH(2)) u0 (.*);

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; tick(); tick(); rst_n = 1; irq_mask = 0;
    endtask
    task automatic set_cfg(input bit chain);
        cfg_we = 1; cfg_wdata = 8'(chain) << 6; tick(); cfg_we = 0;
    endtask
    task automatic put(input bit dir, input int d);
        cmd_we = 1; cmd_dir = dir; cmd_data = CMD_W'(d); tick(); cmd_we = 0;
    endtask
    task automatic take(input bit dir);
        if (dir) rx_cmd_take = 1; else tx_cmd_take = 1;
        tick(); rx_cmd_take = 0; tx_cmd_take = 0;
    endtask
    task automatic fin(input bit dir, input int s);
        if (dir) begin rx_done = 1; rx_status = STAT_W'(s); end
        else begin tx_done = 1; tx_status = STAT_W'(s); end
        tick(); rx_done = 0; tx_done = 0;
    endtask
    task automatic spop(input bit dir);
        if (dir) rx_stat_pop = 1; else tx_stat_pop = 1;
        tick(); rx_stat_pop = 0; tx_stat_pop = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(!tx_cmd_valid && !rx_cmd_valid, "R1 cmd empty", {tx_cmd_valid, rx_cmd_valid}, 0);
        chk(!tx_stat_valid && !rx_stat_valid, "R1 stat empty", {tx_stat_valid, rx_stat_valid}, 0);
        chk(!irq && cmd_ovf == 0, "R1 irq/ovf", {irq, cmd_ovf}, 0);
    endtask

    task automatic t_legacy();
        do_reset();
        put(0, 8'hA1); put(0, 8'hB2);
        chk(tx_cmd_data == 8'hA1, "R2 head kept", tx_cmd_data, 8'hA1);
        chk(cmd_ovf == 2'b01, "R4 legacy ovf tx", cmd_ovf, 2'b01);
        take(0);
        chk(!tx_cmd_valid, "R2 second dropped", tx_cmd_valid, 0);
        fin(0, 3); fin(0, 5);
        chk(tx_stat_head == 3, "R6 legacy stat head", tx_stat_head, 3);
        spop(0);
        chk(!tx_stat_valid, "R6 legacy extra dropped", tx_stat_valid, 0);
        chk(cmd_ovf == 2'b01, "R4 sticky", cmd_ovf, 2'b01);
    endtask

    task automatic t_chain();
        do_reset(); set_cfg(1);
        put(1, 8'h11); put(0, 8'h22); put(1, 8'h33); put(0, 8'h44);
        chk(tx_cmd_data == 8'h22 && rx_cmd_data == 8'h11, "R5 heads", {tx_cmd_data, rx_cmd_data}, 16'h2211);
        chk(cmd_ovf == 0, "R3 two held", cmd_ovf, 0);
        put(0, 8'h55);
        chk(cmd_ovf == 2'b01, "R4 third tx", cmd_ovf, 2'b01);
        take(0);
        chk(tx_cmd_valid && tx_cmd_data == 8'h44, "R10 next tx", tx_cmd_data, 8'h44);
        take(0);
        chk(!tx_cmd_valid, "R4 third not stored", tx_cmd_valid, 0);
        take(1);
        chk(rx_cmd_data == 8'h33, "R3 rx order", rx_cmd_data, 8'h33);
        put(1, 8'h66); put(1, 8'h77);
        chk(cmd_ovf == 2'b11, "R4 rx ovf", cmd_ovf, 2'b11);
    endtask

    task automatic t_status();
        do_reset(); set_cfg(1);
        chk(!irq, "R7 idle", irq, 0);
        fin(0, 1);
        chk(irq && tx_stat_head == 1, "R7 irq on done", {irq, tx_stat_head}, 5'h11);
        fin(0, 2); fin(0, 9);
        spop(0);
        chk(irq && tx_stat_head == 2, "R6 next entry", {irq, tx_stat_head}, 5'h12);
        spop(0);
        chk(!irq && !tx_stat_valid, "R6 third dropped / R7 clear", {irq, tx_stat_valid}, 0);
    endtask

    task automatic t_mask();
        do_reset(); set_cfg(1);
        irq_mask = 2'b01; fin(0, 4);
        chk(!irq && tx_stat_valid && tx_stat_head == 4, "R8 tx masked", {irq, tx_stat_valid}, 1);
        fin(1, 6);
        chk(irq && rx_stat_head == 6, "R8 rx unmasked", irq, 1);
        irq_mask = 2'b11; tick();
        chk(!irq && rx_stat_valid, "R8 both masked", irq, 0);
        irq_mask = 2'b00; tick();
        chk(irq, "R8 unmask", irq, 1);
    endtask

    task automatic t_flush();
        do_reset(); set_cfg(1);
        put(0, 1); put(0, 2); put(0, 3); put(1, 4); fin(0, 7); fin(1, 8);
        set_cfg(0);
        chk(!tx_cmd_valid && !rx_cmd_valid && !tx_stat_valid && !rx_stat_valid,
            "R9 flushed", {tx_cmd_valid, rx_cmd_valid, tx_stat_valid, rx_stat_valid}, 0);
        chk(cmd_ovf == 0 && !irq, "R9 ovf cleared", {cmd_ovf, irq}, 0);
        put(0, 8'hC3); put(0, 8'hD4);
        chk(cmd_ovf == 2'b01 && tx_cmd_data == 8'hC3, "R9 back to legacy", cmd_ovf, 1);
    endtask

    initial begin
        t_reset(); t_legacy(); t_chain(); t_status(); t_mask(); t_flush();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule